// File: doc/BRIEF.md
# Skewed Decision-Forest Classifier

This block evaluates an ensemble of binary decision trees on a stream of feature vectors and returns, for every vector, the signed total of all tree votes and that total averaged over the ensemble. Each tree is a chain of registered levels. At every level one node compares one selected feature against a threshold and steers the walk to the left or the right child. A leaf table after the last level supplies the tree's signed vote.

The trees are not fed in parallel. The feature vector moves along a register chain, so tree `t` sees a vector exactly `t` cycles after tree 0. A running total follows the same skew. Each tree's vote is added to it in the cycle that vote becomes available, so no adder tree is needed at the end. The result of the last add is the forest result. A new vector may enter on every cycle. A fixed number of cycles later a result leaves on every cycle, in arrival order, with no handshake anywhere.

Node thresholds, feature selections and leaf votes are loaded through a single write port. A tree-select field steers each write, and a kind bit chooses between node and leaf storage. Storage should be written only while no valid vectors are in flight.

Top module: `fc_forest`

## Requirements
- R1: After reset, `out_valid`, `out_sum` and `out_avg` are 0. All node and leaf storage is cleared, so every valid vector then yields a sum of 0.
- R2: Nodes use heap numbering: the root is 1 and the children of node k are 2k and 2k+1. A node steers to 2k when the selected feature, taken unsigned from bits [f*FEAT_W +: FEAT_W] of `in_sample`, is strictly below the unsigned threshold. It steers to 2k+1 otherwise, and this includes equality. After DEPTH levels the heap index h selects leaf h-2^DEPTH.
- R3: A write with `cfg_we`=1 changes only the tree whose index equals `cfg_tree`. With `cfg_leaf`=1 it stores `cfg_val` as the signed vote of leaf `cfg_addr`. With `cfg_leaf`=0 it stores `cfg_feat` and `cfg_val` as the feature index and threshold of node `cfg_addr`.
- R4: For a valid vector, `out_sum` is the exact two's-complement sum of all N_TREES leaf votes, with log2(N_TREES) extra bits so it never wraps.
- R5: `out_avg` is `out_sum` divided by N_TREES and rounded toward minus infinity, for both signs and at the extreme vote values.
- R6: A vector captured with `in_valid`=1 at a rising edge produces `out_valid`=1 exactly N_TREES+DEPTH rising edges later, and at no other time.
- R7: Vectors offered on consecutive cycles produce results on consecutive cycles, one per vector, in arrival order.
- R8: Cycles with `in_valid`=0 produce no result. While `out_valid` is 0, both `out_sum` and `out_avg` read 0.
- R9: A node write to address 0 changes nothing, and driving the write fields while `cfg_we`=0 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Feature vector on `in_sample` is valid this cycle |
| in_sample | input | N_FEAT*FEAT_W (32) | Feature vector, feature f in bits [f*FEAT_W +: FEAT_W] |
| cfg_we | input | 1 | Storage write strobe |
| cfg_leaf | input | 1 | 0: node write, 1: leaf write |
| cfg_tree | input | TREE_W (2) | Tree selected by the write |
| cfg_addr | input | DEPTH (3) | Node heap index (1..2^DEPTH-1) or leaf index (0..2^DEPTH-1) |
| cfg_feat | input | FIDX_W (2) | Feature index stored in a node |
| cfg_val | input | VAL_W (8) | Node threshold (unsigned) or leaf vote (signed) |
| out_valid | output | 1 | A forest result is present |
| out_sum | output | VAL_W+log2(N_TREES) (10) | Signed total of all tree votes |
| out_avg | output | VAL_W (8) | Signed total divided by N_TREES, rounded down |

## Verification
The bench runs a software model of every tree beside the design and compares results on every cycle. The stimulus patterns are chosen so that each one exposes a different class of fault. Blank storage, and storage loaded into one tree only, catch writes that reach the wrong tree and votes that leak between trees. A dense back-to-back stream, and a stream full of random gaps, catch skew or valid-delay errors that would pair a vector with another vector's vote. Vectors set exactly at a root threshold and just below it catch a reversed comparison. Leaf sets that are all maximum, all minimum, or that sum to a small negative total check the width of the accumulator and the rounding of the average.

// File: rtl/fc_pkg.sv
package fc_pkg;

    localparam int DEF_TREES  = 4;
    localparam int DEF_DEPTH  = 3;
    localparam int DEF_FEATS  = 4;
    localparam int DEF_FEAT_W = 8;
    localparam int DEF_VAL_W  = 8;

    typedef enum logic {
        CFG_NODE = 1'b0,
        CFG_LEAF = 1'b1
    } cfg_kind_e;

    // Bits needed to index n items, never less than one.
    function automatic int bits_for(input int n);
        int b;
        b = 1;
        while ((1 << b) < n) b++;
        return b;
    endfunction

endpackage

// File: rtl/fc_tree_stage.sv
module fc_tree_stage #(
    parameter int LEVEL  = 0,
    parameter int DEPTH  = fc_pkg::DEF_DEPTH,
    parameter int N_FEAT = fc_pkg::DEF_FEATS,
    parameter int FEAT_W = fc_pkg::DEF_FEAT_W,
    parameter int VAL_W  = fc_pkg::DEF_VAL_W,
    parameter int FIDX_W = fc_pkg::bits_for(fc_pkg::DEF_FEATS)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [N_FEAT*FEAT_W-1:0] smp_in,
    input  logic [DEPTH:0]           heap_in,
    output logic [N_FEAT*FEAT_W-1:0] smp_out,
    output logic [DEPTH:0]           heap_out,
    input  logic                     wr_en,
    input  logic [DEPTH-1:0]         wr_addr,
    input  logic [FIDX_W-1:0]        wr_feat,
    input  logic [VAL_W-1:0]         wr_val
);

    localparam int NODES = 1 << LEVEL;
    localparam logic [DEPTH:0] HEAP_RST = (DEPTH + 1)'(2 * NODES);

    logic [FIDX_W-1:0] feat_q [NODES];
    logic [VAL_W-1:0]  thr_q  [NODES];

    int               rd_slot;
    int               wr_slot;
    int               feat_sel;
    logic             hit;
    logic [FEAT_W-1:0] probe;
    logic             go_right;

    // Heap indices of this level lie in [NODES, 2*NODES); the low bits give the slot.
    always_comb begin
        rd_slot  = int'(heap_in) % NODES;
        wr_slot  = int'(wr_addr) % NODES;
        hit      = wr_en && (int'(wr_addr) >= NODES) && (int'(wr_addr) < 2 * NODES);
        feat_sel = int'(feat_q[rd_slot]) % N_FEAT;
        probe    = smp_in[feat_sel*FEAT_W +: FEAT_W];
        go_right = !(probe < thr_q[rd_slot]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            smp_out  <= '0;
            heap_out <= HEAP_RST;
            for (int i = 0; i < NODES; i++) begin
                feat_q[i] <= '0;
                thr_q[i]  <= '0;
            end
        end else begin
            smp_out  <= smp_in;
            heap_out <= {heap_in[DEPTH-1:0], go_right};
            if (hit) begin
                feat_q[wr_slot] <= wr_feat;
                thr_q[wr_slot]  <= wr_val;
            end
        end
    end

endmodule

// File: rtl/fc_tree.sv
module fc_tree #(
    parameter int DEPTH  = fc_pkg::DEF_DEPTH,
    parameter int N_FEAT = fc_pkg::DEF_FEATS,
    parameter int FEAT_W = fc_pkg::DEF_FEAT_W,
    parameter int VAL_W  = fc_pkg::DEF_VAL_W,
    parameter int FIDX_W = fc_pkg::bits_for(fc_pkg::DEF_FEATS)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [N_FEAT*FEAT_W-1:0] smp_in,
    input  logic                     node_we,
    input  logic                     leaf_we,
    input  logic [DEPTH-1:0]         wr_addr,
    input  logic [FIDX_W-1:0]        wr_feat,
    input  logic [VAL_W-1:0]         wr_val,
    output logic signed [VAL_W-1:0]  leaf_out
);

    localparam int IDX_W  = DEPTH + 1;
    localparam int LEAVES = 1 << DEPTH;
    localparam int SAMP_W = N_FEAT * FEAT_W;

    logic [SAMP_W-1:0] smp_w  [DEPTH+1];
    logic [IDX_W-1:0]  heap_w [DEPTH+1];

    assign smp_w[0]  = smp_in;
    assign heap_w[0] = IDX_W'(1);

    generate
        for (genvar l = 0; l < DEPTH; l++) begin : g_level
            fc_tree_stage #(
                .LEVEL (l),
                .DEPTH (DEPTH),
                .N_FEAT(N_FEAT),
                .FEAT_W(FEAT_W),
                .VAL_W (VAL_W),
                .FIDX_W(FIDX_W)
            ) u_stage (
                .clk     (clk),
                .rst     (rst),
                .smp_in  (smp_w[l]),
                .heap_in (heap_w[l]),
                .smp_out (smp_w[l+1]),
                .heap_out(heap_w[l+1]),
                .wr_en   (node_we),
                .wr_addr (wr_addr),
                .wr_feat (wr_feat),
                .wr_val  (wr_val)
            );
        end
    endgenerate

    logic signed [VAL_W-1:0] vote_q [LEAVES];
    int                      pick;

    always_comb pick = int'(heap_w[DEPTH]) % LEAVES;

    always_ff @(posedge clk) begin
        if (rst) begin
            leaf_out <= '0;
            for (int j = 0; j < LEAVES; j++) vote_q[j] <= '0;
        end else begin
            leaf_out <= vote_q[pick];
            if (leaf_we) vote_q[int'(wr_addr)] <= $signed(wr_val);
        end
    end

    // The sample copy leaving the last level is not needed past the leaf table.
    logic unused_tail;
    assign unused_tail = ^smp_w[DEPTH];

endmodule

// File: rtl/fc_forest.sv
module fc_forest #(
    parameter int N_TREES = fc_pkg::DEF_TREES,
    parameter int DEPTH   = fc_pkg::DEF_DEPTH,
    parameter int N_FEAT  = fc_pkg::DEF_FEATS,
    parameter int FEAT_W  = fc_pkg::DEF_FEAT_W,
    parameter int VAL_W   = fc_pkg::DEF_VAL_W,
    localparam int TREE_W = fc_pkg::bits_for(N_TREES),
    localparam int FIDX_W = fc_pkg::bits_for(N_FEAT),
    localparam int SHIFT  = $clog2(N_TREES),
    localparam int SUM_W  = VAL_W + SHIFT,
    localparam int SAMP_W = N_FEAT * FEAT_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic [SAMP_W-1:0]       in_sample,
    input  logic                    cfg_we,
    input  logic                    cfg_leaf,
    input  logic [TREE_W-1:0]       cfg_tree,
    input  logic [DEPTH-1:0]        cfg_addr,
    input  logic [FIDX_W-1:0]       cfg_feat,
    input  logic [VAL_W-1:0]        cfg_val,
    output logic                    out_valid,
    output logic signed [SUM_W-1:0] out_sum,
    output logic signed [VAL_W-1:0] out_avg
);

    // Capture edge to result: N_TREES skew/accumulate registers plus DEPTH levels,
    // counted as LAT registered stages including the capture edge.
    localparam int LAT = N_TREES + DEPTH + 1;

    typedef struct packed {
        fc_pkg::cfg_kind_e   kind;
        logic [TREE_W-1:0]   tree;
    } cfg_sel_t;

    cfg_sel_t sel;
    always_comb begin
        sel.kind = fc_pkg::cfg_kind_e'(cfg_leaf);
        sel.tree = cfg_tree;
    end

    // Sample pipeline perpendicular to the tree depth: tree t sees the vector t cycles late.
    logic [SAMP_W-1:0]       skew_q [N_TREES-1];
    logic signed [VAL_W-1:0] vote   [N_TREES];
    logic signed [SUM_W-1:0] acc_q  [N_TREES];
    logic [LAT-1:0]          vld_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_TREES - 1; i++) skew_q[i] <= '0;
        end else begin
            skew_q[0] <= in_sample;
            for (int i = 1; i < N_TREES - 1; i++) skew_q[i] <= skew_q[i-1];
        end
    end

    generate
        for (genvar t = 0; t < N_TREES; t++) begin : g_tree
            logic              node_we;
            logic              leaf_we;
            logic [SAMP_W-1:0] feed;

            assign node_we = cfg_we && (sel.kind == fc_pkg::CFG_NODE) && (int'(sel.tree) == t);
            assign leaf_we = cfg_we && (sel.kind == fc_pkg::CFG_LEAF) && (int'(sel.tree) == t);

            if (t == 0) begin : g_head
                assign feed = in_sample;
            end else begin : g_late
                assign feed = skew_q[t-1];
            end

            fc_tree #(
                .DEPTH (DEPTH),
                .N_FEAT(N_FEAT),
                .FEAT_W(FEAT_W),
                .VAL_W (VAL_W),
                .FIDX_W(FIDX_W)
            ) u_tree (
                .clk     (clk),
                .rst     (rst),
                .smp_in  (feed),
                .node_we (node_we),
                .leaf_we (leaf_we),
                .wr_addr (cfg_addr),
                .wr_feat (cfg_feat),
                .wr_val  (cfg_val),
                .leaf_out(vote[t])
            );
        end
    endgenerate

    // Chained accumulation: acc_q[t-1] and vote[t] belong to the same vector in the same cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_TREES; i++) acc_q[i] <= '0;
            vld_q <= '0;
        end else begin
            acc_q[0] <= SUM_W'(vote[0]);
            for (int i = 1; i < N_TREES; i++) acc_q[i] <= acc_q[i-1] + SUM_W'(vote[i]);
            vld_q <= {vld_q[LAT-2:0], in_valid};
        end
    end

    assign out_valid = vld_q[LAT-1];
    assign out_sum   = out_valid ? acc_q[N_TREES-1] : '0;
    assign out_avg   = out_valid ? VAL_W'(acc_q[N_TREES-1] >>> SHIFT) : '0;

endmodule

// File: rtl/fc_forest_chk.sv
module fc_forest_chk #(
    parameter int N_TREES = 4,
    parameter int DEPTH   = 3,
    parameter int VAL_W   = 8,
    parameter int SUM_W   = 10
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    in_valid,
    input logic                    cfg_we,
    input logic                    cfg_leaf,
    input logic [VAL_W-1:0]        cfg_val,
    input logic                    out_valid,
    input logic signed [SUM_W-1:0] out_sum
);

    localparam int LAT = N_TREES + DEPTH + 1;

    logic [LAT-1:0] seen;
    int             quiet;
    logic           leaf_set;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen     <= '0;
            quiet    <= LAT;
            leaf_set <= 1'b0;
        end else begin
            seen <= {seen[LAT-2:0], in_valid};
            if (in_valid) quiet <= 0;
            else if (quiet < LAT) quiet <= quiet + 1;
            if (cfg_we && cfg_leaf && (cfg_val != '0)) leaf_set <= 1'b1;
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !out_valid);

    assert_blank_votes_R1: assert property (@(posedge clk) disable iff (rst)
        (!leaf_set && out_valid) |-> (out_sum == '0));

    assert_fixed_latency_R6: assert property (@(posedge clk) disable iff (rst)
        out_valid == seen[LAT-1]);

    assert_no_spurious_R8: assert property (@(posedge clk) disable iff (rst)
        (quiet >= LAT) |-> !out_valid);

endmodule

bind fc_forest fc_forest_chk #(
    .N_TREES(N_TREES),
    .DEPTH  (DEPTH),
    .VAL_W  (VAL_W),
    .SUM_W  (SUM_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .cfg_we   (cfg_we),
    .cfg_leaf (cfg_leaf),
    .cfg_val  (cfg_val),
    .out_valid(out_valid),
    .out_sum  (out_sum)
);

// File: tb/fc_forest_tb.sv
module fc_forest_tb;

    localparam int NT    = 4;
    localparam int D     = 3;
    localparam int NF    = 4;
    localparam int LAT   = NT + D + 1;
    localparam int NLEAF = 1 << D;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic [31:0]       in_sample = '0;
    logic              cfg_we = 1'b0;
    logic              cfg_leaf = 1'b0;
    logic [1:0]        cfg_tree = '0;
    logic [2:0]        cfg_addr = '0;
    logic [1:0]        cfg_feat = '0;
    logic [7:0]        cfg_val = '0;
    logic              out_valid;
    logic signed [9:0] out_sum;
    logic signed [7:0] out_avg;

    fc_forest #(.N_TREES(NT), .DEPTH(D), .N_FEAT(NF), .FEAT_W(8), .VAL_W(8)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
        .cfg_we(cfg_we), .cfg_leaf(cfg_leaf), .cfg_tree(cfg_tree), .cfg_addr(cfg_addr),
        .cfg_feat(cfg_feat), .cfg_val(cfg_val),
        .out_valid(out_valid), .out_sum(out_sum), .out_avg(out_avg)
    );

    always #2 clk = ~clk;

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 1'b0;
    string sum_tag  = "R4 sum";
    int    n_out    = 0;

    int m_feat [NT][16];
    int m_thr  [NT][16];
    int m_vote [NT][NLEAF];

    int q_v [$];
    int q_s [$];

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int tree_eval(input int t, input logic [31:0] s);
        int k;
        int f;
        int v;
        k = 1;
        for (int l = 0; l < D; l++) begin
            f = m_feat[t][k] % NF;
            v = int'((s >> (8 * f)) & 32'hFF);
            k = (v < m_thr[t][k]) ? 2 * k : 2 * k + 1;
        end
        return m_vote[t][k - NLEAF];
    endfunction

    function automatic int floor_div(input int s, input int n);
        int r;
        r = ((s % n) + n) % n;
        return (s - r) / n;
    endfunction

    // Reference model: result of the vector captured at each edge.
    always @(posedge clk) begin
        int sum;
        sum = 0;
        for (int t = 0; t < NT; t++) sum += tree_eval(t, in_sample);
        q_v.push_back((!rst && in_valid) ? 1 : 0);
        q_s.push_back(sum);
    end

    always @(negedge clk) begin
        int ev;
        int es;
        if (q_v.size() == LAT) begin
            ev = q_v.pop_front();
            es = q_s.pop_front();
            if (!rst && !done) begin
                chk("R6 out_valid timing", int'(out_valid), ev);
                if (ev != 0) begin
                    n_out++;
                    chk(sum_tag, int'(out_sum), es);
                    chk("R5 out_avg", int'(out_avg), floor_div(es, NT));
                end else begin
                    chk("R8 idle out_sum zero", int'(out_sum), 0);
                    chk("R8 idle out_avg zero", int'(out_avg), 0);
                end
            end
        end
    end

    task automatic put_node(input int t, input int k, input int f, input int thr);
        cfg_we = 1'b1; cfg_leaf = 1'b0; cfg_tree = 2'(t); cfg_addr = 3'(k);
        cfg_feat = 2'(f); cfg_val = 8'(thr);
        if (k >= 1) begin m_feat[t][k] = f; m_thr[t][k] = thr; end
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic put_leaf(input int t, input int j, input int v);
        cfg_we = 1'b1; cfg_leaf = 1'b1; cfg_tree = 2'(t); cfg_addr = 3'(j);
        cfg_feat = '0; cfg_val = 8'(v);
        m_vote[t][j] = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic send(input bit v, input logic [31:0] s);
        in_valid = v; in_sample = s;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic program_all();
        for (int t = 0; t < NT; t++) begin
            for (int k = 1; k < NLEAF; k++) put_node(t, k, (t + k) % NF, (37 * k + 53 * t + 20) % 256);
            for (int j = 0; j < NLEAF; j++) put_leaf(t, j, ((t * 29 + j * 41 + 3) % 256) - 128);
        end
    endtask

    task automatic fill_votes(input int v0, input int v1, input int v2, input int v3);
        for (int j = 0; j < NLEAF; j++) begin
            put_leaf(0, j, v0); put_leaf(1, j, v1); put_leaf(2, j, v2); put_leaf(3, j, v3);
        end
    endtask

    initial begin
        for (int t = 0; t < NT; t++) begin
            for (int k = 0; k < 16; k++) begin m_feat[t][k] = 0; m_thr[t][k] = 0; end
            for (int j = 0; j < NLEAF; j++) m_vote[t][j] = 0;
        end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        chk("R1 reset out_valid", int'(out_valid), 0);
        chk("R1 reset out_sum", int'(out_sum), 0);
        chk("R1 reset out_avg", int'(out_avg), 0);

        sum_tag = "R1 unprogrammed sum";
        for (int i = 0; i < 10; i++) send(1'b1, $urandom());
        idle(LAT + 2);

        // Only tree 2 gets votes: the sum must equal its vote alone.
        for (int j = 0; j < NLEAF; j++) put_leaf(2, j, j * 16 - 60);
        sum_tag = "R3 single tree sum";
        for (int i = 0; i < 6; i++) send(1'b1, $urandom());
        idle(LAT + 2);

        program_all();
        sum_tag = "R7 back-to-back sum";
        n_out = 0;
        for (int i = 0; i < 40; i++) send(1'b1, $urandom());
        idle(LAT + 2);
        chk("R7 results per burst", n_out, 40);

        sum_tag = "R8 gapped sum";
        for (int i = 0; i < 60; i++) send(1'($urandom() % 2), $urandom());
        idle(LAT + 2);

        sum_tag = "R2 threshold boundary sum";
        for (int t = 0; t < NT; t++) begin
            send(1'b1, {4{8'(m_thr[t][1])}});
            send(1'b1, {4{8'(m_thr[t][1] - 1)}});
            send(1'b1, {4{8'(m_thr[t][2])}});
            send(1'b1, {4{8'(m_thr[t][3] - 1)}});
        end
        idle(LAT + 2);

        fill_votes(127, 127, 127, 127);
        sum_tag = "R4 max vote sum";
        for (int i = 0; i < 4; i++) send(1'b1, $urandom());
        idle(LAT + 2);

        fill_votes(-128, -128, -128, -128);
        sum_tag = "R4 min vote sum";
        for (int i = 0; i < 4; i++) send(1'b1, $urandom());
        idle(LAT + 2);

        fill_votes(-3, -2, 0, 0);
        sum_tag = "R5 floor sum";
        for (int i = 0; i < 4; i++) send(1'b1, $urandom());
        idle(LAT + 2);

        program_all();
        put_node(0, 0, 3, 200);
        cfg_we = 1'b0; cfg_leaf = 1'b1; cfg_tree = 2'd1; cfg_addr = 3'd7; cfg_val = 8'd99;
        @(negedge clk);
        sum_tag = "R9 ignored write sum";
        for (int i = 0; i < 16; i++) send(1'b1, $urandom());
        idle(LAT + 2);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule